// File: doc/BRIEF.md
# Configurable multiply-accumulate unit

This unit is a small arithmetic block whose function is set by a 3-bit mode code that the surrounding logic may change on any cycle. It holds one 8x8 multiplier, a 16-bit adder with carry-in and a 17-bit result register. The mode code picks the multiplier's A byte. It picks what the adder sums: an operand, the product, or the register's own output fed back. It also picks whether the output shows the adder directly or the register.

Each multiplier operand is read as signed or unsigned under its own flag. The 16-bit product is then sign- or zero-extended before it enters the adder. The adder's 17-bit result carries its carry in bit 16, and that bit also drives the carry-out. Registered and accumulating modes load the register on each rising clock edge. Unregistered modes leave it alone, so an accumulated total survives a detour through combinational modes.

Top module: `mac_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the result register to zero; in any mode that shows the register, `q` reads 0 on the cycle after reset.
- R2: Mode 3'b000 drives `q` in the same cycle with the zero-extended 16-bit product of `a_in[7:0]` and `b_in[7:0]`; `c_in` is ignored, and `q[16]` and `c_out` are 0.
- R3: Mode 3'b001 drives `q` in the same cycle with product(`a_in[7:0]`,`b_in[7:0]`) + `b_in` + `c_in` as a 17-bit sum.
- R4: Mode 3'b011 drives `q` in the same cycle with `a_in` + `b_in` + `c_in` as a 17-bit sum.
- R5: Mode 3'b010 loads the register with reg[15:0] + `a_in` + `c_in` on each rising edge, and `q` shows the register.
- R6: Mode 3'b110 loads the register with reg[15:0] + product(`a_in[15:8]`,`b_in[7:0]`) + `c_in` on each rising edge, and `q` shows the register.
- R7: Modes 3'b100, 3'b101 and 3'b111 compute multiply (carry-in ignored), multiply-add and add as in R2 to R4, but take the multiplier's A byte from `a_in[15:8]`; the sum is loaded on the rising edge and `q` shows the register.
- R8: `sgn_a` = 1 makes the selected A byte two's complement and `sgn_b` = 1 does the same for `b_in[7:0]`, each independently; 0 means unsigned. The product is extended to 16 bits by sign (signed) or zeros (unsigned) before addition.
- R9: Modes 3'b000, 3'b001 and 3'b011 do not change the register; a later mode that shows the register reads the value held from before.
- R10: `c_out` always equals bit 16 of the current adder result, in every mode.
- R11: Feedback uses only the register's low 16 bits, so accumulation wraps modulo 2^16 and a carry out of that sum appears in `q[16]` of the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register loads on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the result register |
| a_in | input | 16 | Operand A; low or high byte feeds the multiplier |
| b_in | input | 16 | Operand B; low byte feeds the multiplier |
| sgn_a | input | 1 | 1: multiplier A byte is signed |
| sgn_b | input | 1 | 1: multiplier B byte is signed |
| c_in | input | 1 | Adder carry-in |
| mode | input | 3 | Function select, see R2 to R7 |
| q | output | 17 | Result: adder output or register, per mode |
| c_out | output | 1 | Bit 16 of the adder result |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and that mode changes only between edges, so that the $past-based accumulate check sees a stable operand per cycle. The stimulus drives all inputs on the falling edge from the bench and never leaves them undriven after time zero. The random part draws every mode code with full-range operands and sign flags. Directed sequences reach signed extremes, accumulator wraparound and holding the register across unregistered modes.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        MD_MUL     = 3'b000,
        MD_MULADD  = 3'b001,
        MD_ACC     = 3'b010,
        MD_ADD     = 3'b011,
        MD_RMUL    = 3'b100,
        MD_RMULADD = 3'b101,
        MD_MAC     = 3'b110,
        MD_RADD    = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'd0,
        YS_OPB  = 2'd1,
        YS_FBK  = 2'd2
    } ysel_e;

    typedef struct packed {
        logic  x_is_prod;   // first adder input: product (1) or operand A (0)
        ysel_e ysel;        // second adder input
        logic  use_cin;     // carry-in honoured
        logic  hi_byte;     // multiplier takes A[15:8]
        logic  load;        // register captures the sum
        logic  show_reg;    // q shows the register
    } ctrl_t;

    function automatic ctrl_t decode_mode(input logic [2:0] m);
        ctrl_t c;
        mode_e md;
        md         = mode_e'(m);
        c.hi_byte  = m[2];
        c.load     = m[2] | (md == MD_ACC);
        c.show_reg = c.load;
        unique case (md)
            MD_MUL, MD_RMUL: begin
                c.x_is_prod = 1'b1; c.ysel = YS_ZERO; c.use_cin = 1'b0;
            end
            MD_MULADD, MD_RMULADD: begin
                c.x_is_prod = 1'b1; c.ysel = YS_OPB;  c.use_cin = 1'b1;
            end
            MD_ACC: begin
                c.x_is_prod = 1'b0; c.ysel = YS_FBK;  c.use_cin = 1'b1;
            end
            MD_MAC: begin
                c.x_is_prod = 1'b1; c.ysel = YS_FBK;  c.use_cin = 1'b1;
            end
            default: begin
                c.x_is_prod = 1'b0; c.ysel = YS_OPB;  c.use_cin = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic [2:0] mode,
    output ctrl_t      ctl
);
    always_comb ctl = decode_mode(mode);
endmodule

// File: rtl/mac_mul.sv
module mac_mul #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]   a_op,
    input  logic [BW-1:0]   b_op,
    input  logic            sgn_a,
    input  logic            sgn_b,
    output logic [2*BW-1:0] prod
);
    localparam int PW = 2 * BW;

    logic [1:0][BW-1:0] ops;
    logic [1:0]         sgn;
    logic [1:0][PW-1:0] ext;

    assign ops = {b_op, a_op};
    assign sgn = {sgn_b, sgn_a};

    // Extend each operand to the product width; modular product is then exact.
    for (genvar i = 0; i < 2; i++) begin : g_ext
        assign ext[i] = {{BW{sgn[i] & ops[i][BW-1]}}, ops[i]};
    end

    assign prod = ext[0] * ext[1];
endmodule

// File: rtl/mac_add.sv
module mac_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W:0]   sum
);
    assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
endmodule

// File: rtl/mac_accreg.sv
module mac_accreg #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] qr
);
    always_ff @(posedge clk) begin
        if (rst)       qr <= '0;
        else if (load) qr <= d;
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    input  logic           sgn_a,
    input  logic           sgn_b,
    input  logic           c_in,
    input  logic [2:0]     mode,
    output logic [OPW:0]   q,
    output logic           c_out
);
    localparam int BW = OPW / 2;
    localparam int SW = OPW + 1;

    ctrl_t          ctl;
    logic [BW-1:0]  a_byte;
    logic [OPW-1:0] prod;
    logic [OPW-1:0] add_x;
    logic [OPW-1:0] add_y;
    logic [SW-1:0]  sum;
    logic [SW-1:0]  acc;

    mac_ctrl u_ctrl (
        .mode (mode),
        .ctl  (ctl)
    );

    assign a_byte = ctl.hi_byte ? a_in[OPW-1 -: BW] : a_in[BW-1:0];

    mac_mul #(.BW(BW)) u_mul (
        .a_op  (a_byte),
        .b_op  (b_in[BW-1:0]),
        .sgn_a (sgn_a),
        .sgn_b (sgn_b),
        .prod  (prod)
    );

    always_comb begin
        add_x = ctl.x_is_prod ? prod : a_in;
        unique case (ctl.ysel)
            YS_OPB:  add_y = b_in;
            YS_FBK:  add_y = acc[OPW-1:0];
            default: add_y = '0;
        endcase
    end

    mac_add #(.W(OPW)) u_add (
        .x   (add_x),
        .y   (add_y),
        .cin (ctl.use_cin & c_in),
        .sum (sum)
    );

    mac_accreg #(.W(SW)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .d    (sum),
        .qr   (acc)
    );

    assign q     = ctl.show_reg ? acc : sum;
    assign c_out = sum[OPW];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int OPW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] a_in,
    input logic           sgn_a,
    input logic           sgn_b,
    input logic           c_in,
    input logic [2:0]     mode,
    input logic [OPW:0]   q,
    input logic           c_out
);
    function automatic logic shows(input logic [2:0] m);
        return m[2] | (m == 3'b010);
    endfunction

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && shows(mode)) |-> (q == '0));  // R1

    AST_MUL_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000) |-> (!q[OPW] && !c_out));  // R2

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'b010 && mode == 3'b010)
        |-> (q == ({1'b0, $past(q[OPW-1:0])} + {1'b0, $past(a_in)}
                   + {{OPW{1'b0}}, $past(c_in)})));  // R5

    AST_UNSIGNED_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000 && !sgn_a && !sgn_b)
        |-> (q[OPW-1:0] <= ((2**(OPW/2)) - 1) * ((2**(OPW/2)) - 1)));  // R8

    AST_COUT_UNREG: assert property (@(posedge clk) disable iff (rst)
        (!shows(mode)) |-> (c_out == q[OPW]));  // R10
endmodule

bind mac_unit mac_unit_chk #(.OPW(OPW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .a_in  (a_in),
    .sgn_a (sgn_a),
    .sgn_b (sgn_b),
    .c_in  (c_in),
    .mode  (mode),
    .q     (q),
    .c_out (c_out)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        sgn_a = 1'b0;
    logic        sgn_b = 1'b0;
    logic        c_in = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [16:0] q;
    logic        c_out;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;
    logic [16:0] mreg = '0;   // bench's own model of the result register

    mac_unit u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .c_in(c_in), .mode(mode),
        .q(q), .c_out(c_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic vis(input logic [2:0] m);
        return m[2] | (m == 3'b010);
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b011: return "R4";
            3'b010: return "R5";
            3'b110: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference from the requirements: adder result for mode m.
    function automatic logic [16:0] ref_sum(input logic [2:0] m, input logic [15:0] a, b,
                                            input logic sa, sb, ci, input logic [16:0] acc);
        logic [7:0]  ab;
        logic [15:0] ea, eb, p, x, y;
        logic        c;
        ab = m[2] ? a[15:8] : a[7:0];
        ea = sa ? {{8{ab[7]}}, ab} : {8'h00, ab};
        eb = sb ? {{8{b[7]}}, b[7:0]} : {8'h00, b[7:0]};
        p  = ea * eb;
        case (m)
            3'b000, 3'b100: begin x = p; y = '0;        c = 1'b0; end
            3'b001, 3'b101: begin x = p; y = b;         c = ci;   end
            3'b010:         begin x = a; y = acc[15:0]; c = ci;   end
            3'b110:         begin x = p; y = acc[15:0]; c = ci;   end
            default:        begin x = a; y = b;         c = ci;   end
        endcase
        return {1'b0, x} + {1'b0, y} + {16'h0, c};
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (mode=%b a=%h b=%h)",
                     req, act, exp_v, mode, a_in, b_in);
        end
    endtask

    // Drive on the falling edge, check before the rising edge, advance the model.
    task automatic step(input logic [2:0] m, input logic [15:0] a, b,
                        input logic sa, sb, ci, input string tag);
        logic [16:0] s;
        string r;
        @(negedge clk);
        mode = m; a_in = a; b_in = b; sgn_a = sa; sgn_b = sb; c_in = ci;
        #1;
        s = ref_sum(m, a, b, sa, sb, ci, mreg);
        r = (tag == "") ? req_of(m) : tag;
        check(r, q, vis(m) ? mreg : s);
        check("R10", {16'h0, c_out}, {16'h0, s[16]});
        @(posedge clk);
        if (rst)         mreg = '0;
        else if (vis(m)) mreg = s;
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        mreg = '0;
        @(negedge clk);
        rst = 1'b0;
        // R1: register reads zero after reset
        step(3'b110, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R1");

        // R8: sign handling, mode 000 low bytes
        step(3'b000, 16'h0080, 16'h0080, 1'b1, 1'b1, 1'b1, "R8"); // 4000
        step(3'b000, 16'h0080, 16'h0080, 1'b1, 1'b0, 1'b0, "R8"); // C000
        step(3'b000, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b0, "R8"); // FE01
        step(3'b000, 16'h00FF, 16'h00FF, 1'b1, 1'b1, 1'b0, "R8"); // 0001
        step(3'b000, 16'h00FF, 16'h0001, 1'b1, 1'b0, 1'b0, "R8"); // FFFF
        // R3, R4 carry out of bit 15
        step(3'b001, 16'h00FF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R3");
        step(3'b011, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b1, "R4");

        // R11: wraparound of the accumulator
        step(3'b111, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, "R7");
        step(3'b010, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, "R11");
        step(3'b010, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, "R11");
        step(3'b010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R11");
        @(negedge clk); #1;
        check("R11", q, 17'h00001);

        // R9: register held through unregistered modes
        step(3'b111, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, "R7");
        step(3'b001, 16'hABCD, 16'h5555, 1'b1, 1'b0, 1'b1, "R3");
        step(3'b011, 16'h7777, 16'h8888, 1'b0, 1'b0, 1'b1, "R4");
        step(3'b000, 16'h0F0F, 16'h00F0, 1'b0, 1'b1, 1'b1, "R2");
        @(negedge clk);
        mode = 3'b010; a_in = '0; c_in = 1'b0;
        #1;
        check("R9", q, 17'h01234);
        // R6: MAC with high byte
        step(3'b110, 16'h0300, 16'h0004, 1'b0, 1'b0, 1'b0, "R6");
        step(3'b110, 16'hFF00, 16'h0002, 1'b1, 1'b0, 1'b1, "R6");
        step(3'b010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R6");

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); mreg = '0;
        @(negedge clk); rst = 1'b0;
        step(3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R1");

        // Random mix of all modes
        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom()), 16'($urandom()), 16'($urandom()),
                 1'($urandom()), 1'($urandom()), 1'($urandom()), "");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule